// File: doc/BRIEF.md
# Network Controller Interrupt Status Unit

This block collects single-cycle event pulses from the receive and transmit paths of a network controller into a sticky pending register. Each pending bit is qualified by a per-source enable bit, and the combined result is qualified again by one global mask bit before it drives a single interrupt line to the processor. Four sources are handled by default: three receive-side sources on bits 2:0 and the transmit source on bit 3.

Software sees the pending register at two addresses. The keeping view returns the bits and leaves them alone. The draining view returns the bits and clears exactly those it returned, so a driver's handler reads it once, acts on the value, and treats zero as "nothing to do". Writing ones to the keeping view raises pending bits by hand. A driver uses this after turning receive interrupts back on to make sure work that arrived while they were off still triggers a call.

The register port is a plain single-cycle read/write port. Read data is combinational from the address while the read strobe is high. A draining read takes effect at the clock edge that ends the read cycle.

Top module: `net_irq_status`

## Requirements
- R1: After reset the pending bits, the enable bits and the global mask are all zero, `irq_o` is low, and every register reads zero. Reads of any unmapped address also return zero.
- R2: A pulse on `evt_i[i]` sets pending bit i at the next clock edge, whatever the value of enable bit i.
- R3: A read of the keeping view at byte address 0x04 returns the pending bits in bits NSRC-1:0, with zeros above, and leaves the pending bits unchanged.
- R4: A read of the draining view at byte address 0x08 returns the pending bits and clears every returned bit at the clock edge that ends the read. A following draining read with no new events returns zero.
- R5: If an event on source i arrives in the same cycle as a draining read, pending bit i is still set after that edge.
- R6: A write to the keeping view sets every pending bit whose write-data bit is one. Write-data bits that are zero clear nothing.
- R7: `irq_o` is a register. One clock after any pending bit and its enable bit are both one while the global mask is one, `irq_o` is high. Otherwise it is low one clock later.
- R8: The global mask is bit 15 of the register at byte address 0x0C. Only that bit is stored and read back. While it is zero, `irq_o` is held low.
- R9: The enable register at byte address 0x00 stores write-data bits NSRC-1:0 (bit 3 transmit, bits 2:0 receive) and reads them back with zeros above.
- R10: A write to the draining view at 0x08 has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NSRC | Event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid while rd_en_i is high |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A pending bit stuck high or lost shows up at the ports on the next read of either status view. If the bit is enabled and the mask is on, it also shows up one clock later as a wrong level on `irq_o`. A draining read that clears too much or too little shows up on the very next read. A lost event during a draining read is caught because the bench reads again right after the collision. An enable or mask bit that is stored wrongly reaches `irq_o` within one clock once a matching bit is pending, and it also reaches the read port directly.

// File: rtl/net_irq_pkg.sv
package net_irq_pkg;
   localparam int unsigned OFS_ENABLE = 8'h00;
   localparam int unsigned OFS_KEEP   = 8'h04;
   localparam int unsigned OFS_DRAIN  = 8'h08;
   localparam int unsigned OFS_MASK   = 8'h0C;

   typedef struct packed {
      logic wr_enable;
      logic wr_keep;
      logic wr_mask;
      logic rd_drain;
   } reg_strobe_t;
endpackage

// File: rtl/net_irq_sticky.sv
module net_irq_sticky #(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] stat_o
);
   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          stat_o[i] <= 1'b0;
            else if (set_i[i])   stat_o[i] <= 1'b1;
            else if (clr_i[i])   stat_o[i] <= 1'b0;
         end

         AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_o[i] && !clr_i[i]) |=> stat_o[i]); // R3
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> stat_o[i]); // R5
      end
   endgenerate
endmodule

// File: rtl/net_irq_cfg.sv
module net_irq_cfg #(
   parameter int NSRC     = 4,
   parameter int DATA_W   = 32,
   parameter int MASK_BIT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_enable_i,
   input  logic              wr_mask_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [NSRC-1:0]   en_o,
   output logic              mask_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= '0;
         mask_o <= 1'b0;
      end else begin
         if (wr_enable_i) en_o   <= wdata_i[NSRC-1:0];
         if (wr_mask_i)   mask_o <= wdata_i[MASK_BIT];
      end
   end

   AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_enable_i |=> $stable(en_o)); // R9
   AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mask_i |=> $stable(mask_o)); // R8
endmodule

// File: rtl/net_irq_gate.sv
module net_irq_gate #(
   parameter int NSRC    = 4,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] stat_i,
   input  logic [NSRC-1:0] en_i,
   input  logic            mask_i,
   output logic            irq_o
);
   logic any_live;
   assign any_live = |(stat_i & en_i);

   generate
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= any_live & mask_i;
         end
         AST_MASK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !mask_i |=> !irq_o); // R8
         AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_i && any_live) |=> irq_o); // R7
      end else begin : g_comb
         assign irq_o = any_live & mask_i;
      end
   endgenerate
endmodule

// File: rtl/net_irq_status.sv
module net_irq_status #(
   parameter int NSRC     = 4,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int MASK_BIT = 15,
   parameter bit IRQ_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   evt_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   import net_irq_pkg::*;

   localparam int PAD_W = DATA_W - NSRC;

   generate
      if (NSRC < 1 || NSRC > MASK_BIT) begin : g_bad_nsrc
         $error("NSRC must be between 1 and MASK_BIT");
      end
      if (MASK_BIT >= DATA_W) begin : g_bad_mask
         $error("MASK_BIT must be below DATA_W");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   reg_strobe_t     stb;
   logic [NSRC-1:0] stat_q;
   logic [NSRC-1:0] en_q;
   logic            mask_q;
   logic [NSRC-1:0] set_v;
   logic [NSRC-1:0] clr_v;

   always_comb begin
      stb.wr_enable = wr_en_i && (addr_i == ADDR_W'(OFS_ENABLE));
      stb.wr_keep   = wr_en_i && (addr_i == ADDR_W'(OFS_KEEP));
      stb.wr_mask   = wr_en_i && (addr_i == ADDR_W'(OFS_MASK));
      stb.rd_drain  = rd_en_i && (addr_i == ADDR_W'(OFS_DRAIN));
   end

   assign set_v = evt_i | (stb.wr_keep ? wdata_i[NSRC-1:0] : '0);
   assign clr_v = stb.rd_drain ? stat_q : '0;

   net_irq_sticky #(.NSRC(NSRC)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .stat_o(stat_q)
   );

   net_irq_cfg #(.NSRC(NSRC), .DATA_W(DATA_W), .MASK_BIT(MASK_BIT)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_enable_i(stb.wr_enable), .wr_mask_i(stb.wr_mask),
      .wdata_i(wdata_i), .en_o(en_q), .mask_o(mask_q)
   );

   net_irq_gate #(.NSRC(NSRC), .IRQ_REG(IRQ_REG)) u_gate (
      .clk(clk), .rst_n(rst_n), .stat_i(stat_q), .en_i(en_q),
      .mask_i(mask_q), .irq_o(irq_o)
   );

   always_comb begin
      rdata_o = '0;
      if (rd_en_i) begin
         if (addr_i == ADDR_W'(OFS_ENABLE))
            rdata_o = {{PAD_W{1'b0}}, en_q};
         else if (addr_i == ADDR_W'(OFS_KEEP) || addr_i == ADDR_W'(OFS_DRAIN))
            rdata_o = {{PAD_W{1'b0}}, stat_q};
         else if (addr_i == ADDR_W'(OFS_MASK))
            rdata_o[MASK_BIT] = mask_q;
      end
   end

   AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.rd_drain && evt_i == '0) |=> (stat_q == '0)); // R4
   AST_EVT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R2
   AST_KEEP_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      stb.wr_keep |=> ((stat_q & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0]))); // R6
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stb.wr_enable, stb.wr_keep, stb.wr_mask})); // R10
endmodule

// File: tb/net_irq_status_bench.sv
module net_irq_status_bench;
   localparam int NSRC = 4;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NSRC-1:0]   evt_i = '0;
   logic              wr_en_i = 1'b0;
   logic              rd_en_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic [DATA_W-1:0] wdata_i = '0;
   logic [DATA_W-1:0] rdata_o;
   logic              irq_o;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // behavioural reference state
   logic [3:0] m_stat = '0;
   logic [3:0] m_en = '0;
   logic       m_mask = 1'b0;
   logic       m_irq = 1'b0;

   always #4 clk = ~clk;

   net_irq_status u_net_irq_status (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
      .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .irq_o(irq_o)
   );

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a)
         8'h00:        return {28'd0, m_en};
         8'h04, 8'h08: return {28'd0, m_stat};
         8'h0C:        return {16'd0, m_mask, 15'd0};
         default:      return 32'd0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // one bus cycle; irq compared every cycle against the model
   task automatic cyc(input string tag, input logic [3:0] ev, input logic wr, input logic rd,
                      input logic [7:0] a, input logic [31:0] d);
      logic       irq_n;
      logic [3:0] set_v;
      logic [3:0] clr_v;
      @(negedge clk);
      check("R7 irq level", {31'd0, irq_o}, {31'd0, m_irq});
      evt_i = ev; wr_en_i = wr; rd_en_i = rd; addr_i = a; wdata_i = d;
      #1;
      if (rd) check(tag, rdata_o, model_read(a));
      @(posedge clk);
      irq_n = ((m_stat & m_en) != 4'd0) && m_mask;
      set_v = ev | ((wr && a == 8'h04) ? d[3:0] : 4'd0);
      clr_v = (rd && a == 8'h08) ? m_stat : 4'd0;
      m_stat = set_v | (m_stat & ~clr_v);
      if (wr && a == 8'h00) m_en = d[3:0];
      if (wr && a == 8'h0C) m_mask = d[15];
      m_irq = irq_n;
      #1;
      evt_i = '0; wr_en_i = 1'b0; rd_en_i = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) cyc("R7", 4'd0, 1'b0, 1'b0, 8'h00, 32'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state of all views and an unmapped address
      cyc("R1 enable", 4'd0, 0, 1, 8'h00, 0);
      cyc("R1 keep",   4'd0, 0, 1, 8'h04, 0);
      cyc("R1 drain",  4'd0, 0, 1, 8'h08, 0);
      cyc("R1 mask",   4'd0, 0, 1, 8'h0C, 0);
      cyc("R1 unmapped", 4'd0, 0, 1, 8'h10, 0);
      // R2: events set bits with enables off
      cyc("R2", 4'b0001, 0, 0, 0, 0);
      cyc("R2", 4'b1000, 0, 0, 0, 0);
      cyc("R2 keep read", 4'd0, 0, 1, 8'h04, 0);
      // R3: keep view twice, unchanged
      cyc("R3 keep read", 4'd0, 0, 1, 8'h04, 0);
      cyc("R3 keep read", 4'd0, 0, 1, 8'h04, 0);
      // R9: enable write and readback, upper bits dropped
      cyc("R9", 4'd0, 1, 0, 8'h00, 32'hFFFF_FFF8);
      cyc("R9 enable read", 4'd0, 0, 1, 8'h00, 0);
      idle(2);                                   // mask off: irq low (R8)
      cyc("R8", 4'd0, 1, 0, 8'h0C, 32'h0000_8000);
      idle(3);                                   // R7 irq high
      cyc("R8 mask read", 4'd0, 0, 1, 8'h0C, 0);
      cyc("R8", 4'd0, 1, 0, 8'h0C, 32'hFFFF_7FFF);
      idle(2);
      cyc("R8 mask read", 4'd0, 0, 1, 8'h0C, 0);
      cyc("R8", 4'd0, 1, 0, 8'h0C, 32'h0000_8000);
      // R4: drain returns, then zero
      cyc("R4 drain", 4'd0, 0, 1, 8'h08, 0);
      cyc("R4 drain empty", 4'd0, 0, 1, 8'h08, 0);
      idle(2);
      // R5: event collides with draining read
      cyc("R5 setup", 4'b0110, 0, 0, 0, 0);
      cyc("R5 drain", 4'b0100, 0, 1, 8'h08, 0);
      cyc("R5 keep read", 4'd0, 0, 1, 8'h04, 0);
      cyc("R5 drain", 4'd0, 0, 1, 8'h08, 0);
      // R6: software set via keep view; zeros clear nothing
      cyc("R6", 4'd0, 1, 0, 8'h04, 32'h0000_0004);
      cyc("R6 keep read", 4'd0, 0, 1, 8'h04, 0);
      cyc("R6", 4'd0, 1, 0, 8'h04, 32'h0000_0000);
      cyc("R6 keep read", 4'd0, 0, 1, 8'h04, 0);
      // R10: write to drain view is ignored
      cyc("R10", 4'd0, 1, 0, 8'h08, 32'hFFFF_FFFF);
      cyc("R10 keep read", 4'd0, 0, 1, 8'h04, 0);
      cyc("R10 enable read", 4'd0, 0, 1, 8'h00, 0);
      cyc("R10 mask read", 4'd0, 0, 1, 8'h0C, 0);
      // mixed traffic against the model
      for (int n = 0; n < 400; n++) begin
         logic [7:0] a;
         logic [3:0] ev;
         logic wr, rd;
         a  = 8'(($urandom % 5) * 4);
         ev = ($urandom % 3 == 0) ? 4'($urandom) : 4'd0;
         wr = ($urandom % 4 == 0);
         rd = !wr && ($urandom % 2 == 0);
         cyc("R3/R4 mixed read", ev, wr, rd, a, $urandom);
      end
      idle(2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule